// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block is the timing heart of a pulse-width modulator channel. A control word picks how a counter of a set width moves on each prescaled tick: up with wrap to zero, down with reload, up then down like a triangle, or frozen. A period word gives the turning point. The counter value, its present direction and two one-clock event strobes (counter reached zero, counter reached the period) go on to the compare and output-action logic downstream.

The counting tick comes from two dividers in series. A coarse divider scales by a power of two. A fine divider scales by one or by an even number. A new period can take effect at once, or it can wait in a shadow register until the counter next reaches zero, so that a running waveform never sees a period change in mid-cycle. Three run behaviours let software halt the counter on the next tick, let it run to the end of the current cycle, or leave it free-running.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter is 0, the direction output is 0 (up), both strobes are low, the control word is 0 and the active period is RST_PRD (default 0).
- R2: Mode 00 in control bits [1:0] counts up by one per tick. From a value at or above the active period P it wraps to 0, and the direction output reads 0.
- R3: Mode 01 counts down by one per tick. From 0 it reloads P, and the direction output reads 1 after its first tick.
- R4: Mode 10 counts up to P and then down to 0, repeatedly. The direction output turns to 1 in the tick where the counter reaches P and back to 0 in the tick where it reaches 0.
- R5: Mode 11 freezes the counter at its present value.
- R6: The tick period in clocks is 2^C × D. C is control bits [12:10]. D is 1 when control bits [9:7] are 0 and twice that field otherwise. Each control write restarts the prescaler, so the first tick that can move the counter comes exactly 2^C × D clocks after the write edge.
- R7: With control bit 3 at 1, a period write changes P at that clock edge. With bit 3 at 0, the write goes to a shadow register that becomes P in the tick where the counter reaches 0.
- R8: Run field 00 in control bits [15:14] stops the counter from the next tick on. It holds its value.
- R9: Run field 01 lets the counter keep moving until it reaches 0, then holds it at 0.
- R10: Run fields 10 and 11 both make the counter run freely.
- R11: The zero strobe and the period strobe are each a one-clock pulse. A pulse appears in the clock where the counter takes the value 0 (or P) through a tick. No pulse appears while the counter is halted or frozen.
- R12: The counter changes only as the result of a prescaled tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 16 | Control word: mode, load select, dividers, run field |
| prd_we | input | 1 | Write strobe for the period value |
| prd_wdata | input | CNT_W | Period value |
| cnt | output | CNT_W | Present counter value |
| dir_down | output | 1 | 1 while the counter is moving downward |
| zero_stb | output | 1 | One-clock pulse when the counter reaches 0 |
| prd_stb | output | 1 | One-clock pulse when the counter reaches the period |

## Verification
A wrong turning point or direction register shows on `cnt` and `dir_down` within the same tick in which the counter arrives at 0 or at the period. A wrong shadow transfer shows only one full cycle later, when the counter wraps at the old or at the new period. A prescaler fault shifts the first counter step by whole clocks after a control write, so the bench samples right at that step and one clock before it. Halt faults show as a counter that keeps moving, or as stray strobes, during a long quiet window.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;

   localparam int CTL_W     = 16;
   localparam int COARSE_W  = 3;
   localparam int FINE_W    = 3;
   // largest total division: 2^(2^COARSE_W-1) * 2*(2^FINE_W-1)
   localparam int MAX_DIV   = (2 ** (2 ** COARSE_W - 1)) * (2 * (2 ** FINE_W - 1));
   localparam int PRE_W     = $clog2(MAX_DIV);

   typedef enum logic [1:0] {
      CM_UP   = 2'b00,
      CM_DOWN = 2'b01,
      CM_UPDN = 2'b10,
      CM_HOLD = 2'b11
   } cmode_e;

   typedef enum logic [1:0] {
      RN_HALT   = 2'b00,
      RN_CYCLE  = 2'b01,
      RN_FREE_A = 2'b10,
      RN_FREE   = 2'b11
   } run_e;

   typedef struct packed {
      run_e                run;     // [15:14]
      logic                rsv13;   // [13]
      logic [COARSE_W-1:0] coarse;  // [12:10]
      logic [FINE_W-1:0]   fine;    // [9:7]
      logic [2:0]          rsv6_4;  // [6:4]
      logic                imm;     // [3]
      logic                rsv2;    // [2]
      cmode_e              mode;    // [1:0]
   } ctl_t;

endpackage

// File: rtl/pwmtb_prescaler.sv
module pwmtb_prescaler
   import pwmtb_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic [COARSE_W-1:0] coarse,
   input  logic [FINE_W-1:0]   fine,
   output logic                tick
);

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] div_c;
   logic [PRE_W-1:0] div_f;
   logic [PRE_W-1:0] total;

   always_comb begin
      div_c = PRE_W'(1) << coarse;
      div_f = (fine == '0) ? PRE_W'(1) : PRE_W'({fine, 1'b0});
      total = div_c * div_f;
      tick  = (pre_q == total - PRE_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               pre_q <= '0;
      else if (restart || tick) pre_q <= '0;
      else                      pre_q <= pre_q + PRE_W'(1);
   end

endmodule

// File: rtl/pwmtb_period.sv
module pwmtb_period #(
   parameter int                 CNT_W   = 16,
   parameter logic [CNT_W-1:0]   RST_PRD = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             imm,
   input  logic             xfer,
   output logic [CNT_W-1:0] active
);

   logic [CNT_W-1:0] shadow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= RST_PRD;
         active   <= RST_PRD;
      end else begin
         if (wr) shadow_q <= wdata;
         if (wr && imm)  active <= wdata;
         else if (xfer)  active <= shadow_q;
      end
   end

endmodule

// File: rtl/pwmtb_counter.sv
module pwmtb_counter
   import pwmtb_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  cmode_e           mode,
   input  run_e             run,
   input  logic [CNT_W-1:0] prd,
   output logic [CNT_W-1:0] cnt,
   output logic             dir_down,
   output logic             zero_stb,
   output logic             prd_stb,
   output logic             reach_zero
);

   logic [CNT_W-1:0] nxt;
   logic             dir_n;
   logic             run_ok;
   logic             adv;

   always_comb begin
      unique case (run)
         RN_HALT:  run_ok = 1'b0;
         RN_CYCLE: run_ok = (cnt != '0);
         default:  run_ok = 1'b1;
      endcase
      adv = tick && run_ok && (mode != CM_HOLD);
   end

   always_comb begin
      nxt   = cnt;
      dir_n = dir_down;
      unique case (mode)
         CM_UP: begin
            dir_n = 1'b0;
            nxt   = (cnt >= prd) ? '0 : cnt + 1'b1;
         end
         CM_DOWN: begin
            dir_n = 1'b1;
            nxt   = (cnt == '0) ? prd : cnt - 1'b1;
         end
         CM_UPDN: begin
            if (!dir_down) begin
               if (cnt < prd)       nxt = cnt + 1'b1;
               else if (cnt == '0)  nxt = '0;
               else                 nxt = cnt - 1'b1;
            end else begin
               if (cnt == '0)       nxt = (prd == '0) ? '0 : cnt + 1'b1;
               else                 nxt = cnt - 1'b1;
            end
            if (nxt == '0)          dir_n = 1'b0;
            else if (nxt >= prd)    dir_n = 1'b1;
         end
         default: ;
      endcase
      reach_zero = adv && (nxt == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         dir_down <= 1'b0;
         zero_stb <= 1'b0;
         prd_stb  <= 1'b0;
      end else begin
         zero_stb <= reach_zero;
         prd_stb  <= adv && (nxt == prd);
         if (adv) begin
            cnt      <= nxt;
            dir_down <= dir_n;
         end
      end
   end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
   import pwmtb_pkg::*;
#(
   parameter int               CNT_W       = 16,
   parameter bit               PRESCALE_EN = 1'b1,
   parameter logic [CNT_W-1:0] RST_PRD     = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [15:0]      ctl_wdata,
   input  logic             prd_we,
   input  logic [CNT_W-1:0] prd_wdata,
   output logic [CNT_W-1:0] cnt,
   output logic             dir_down,
   output logic             zero_stb,
   output logic             prd_stb
);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("pwm_timebase: CNT_W must lie in 2..32");
   end
   if (CTL_W != 16) begin : g_bad_ctl
      $error("pwm_timebase: control word layout assumes 16 bits");
   end

   ctl_t             ctl_q;
   logic             tick;
   logic             reach_zero;
   logic [CNT_W-1:0] prd_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
   end

   if (PRESCALE_EN) begin : g_presc
      pwmtb_prescaler u_presc (
         .clk     (clk),
         .rst_n   (rst_n),
         .restart (ctl_we),
         .coarse  (ctl_q.coarse),
         .fine    (ctl_q.fine),
         .tick    (tick)
      );
   end else begin : g_nopresc
      assign tick = 1'b1;
   end

   pwmtb_period #(.CNT_W(CNT_W), .RST_PRD(RST_PRD)) u_prd (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (prd_we),
      .wdata  (prd_wdata),
      .imm    (ctl_q.imm),
      .xfer   (reach_zero),
      .active (prd_act)
   );

   pwmtb_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .mode       (ctl_q.mode),
      .run        (ctl_q.run),
      .prd        (prd_act),
      .cnt        (cnt),
      .dir_down   (dir_down),
      .zero_stb   (zero_stb),
      .prd_stb    (prd_stb),
      .reach_zero (reach_zero)
   );

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
   import pwmtb_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input ctl_t             ctl_q,
   input logic [CNT_W-1:0] cnt,
   input logic             dir_down,
   input logic             zero_stb,
   input logic             prd_stb
);

   // R12
   a_r12_moves_on_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));

   // R5
   a_r5_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.mode == CM_HOLD) |=> $stable(cnt));

   // R8
   a_r8_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.run == RN_HALT) |=> $stable(cnt));

   // R11
   a_r11_zero_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      zero_stb |-> ($past(tick) && cnt == '0));

   // R11
   a_r11_prd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      prd_stb |-> $past(tick));

   // R2
   a_r2_up_direction: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ctl_q.mode == CM_UP && ctl_q.run == RN_FREE) |=> !dir_down);

   // R3
   a_r3_down_direction: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ctl_q.mode == CM_DOWN && ctl_q.run == RN_FREE) |=> dir_down);

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .ctl_q    (ctl_q),
   .cnt      (cnt),
   .dir_down (dir_down),
   .zero_stb (zero_stb),
   .prd_stb  (prd_stb)
);

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;

   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ctl_we = 1'b0;
   logic [15:0]      ctl_wdata = '0;
   logic             prd_we = 1'b0;
   logic [CNT_W-1:0] prd_wdata = '0;
   logic [CNT_W-1:0] cnt;
   logic             dir_down;
   logic             zero_stb;
   logic             prd_stb;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   pwm_timebase #(.CNT_W(CNT_W)) u_pwm_timebase (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we),
      .ctl_wdata (ctl_wdata),
      .prd_we    (prd_we),
      .prd_wdata (prd_wdata),
      .cnt       (cnt),
      .dir_down  (dir_down),
      .zero_stb  (zero_stb),
      .prd_stb   (prd_stb)
   );

   // control word, period, ticks after start, expected count, expected direction
   localparam int NV = 11;
   localparam logic [15:0] V_CTL [NV] = '{
      16'hC000, 16'hC000,             // R2
      16'hC001, 16'hC001, 16'hC001,   // R3
      16'hC002, 16'hC002, 16'hC002,   // R4
      16'hC003,                       // R5
      16'h8000,                       // R10
      16'hC000                        // R2 zero period
   };
   localparam int V_PRD [NV] = '{5, 5, 5, 5, 4, 4, 4, 4, 5, 5, 0};
   localparam int V_N   [NV] = '{3, 7, 1, 3, 6, 4, 6, 8, 5, 3, 3};
   localparam int V_CNT [NV] = '{3, 1, 5, 3, 4, 4, 2, 0, 0, 3, 0};
   localparam int V_DIR [NV] = '{0, 0, 1, 1, 1, 1, 1, 0, 0, 0, 0};
   localparam string V_REQ [NV] = '{"R2", "R2", "R3", "R3", "R3", "R4", "R4", "R4",
                                    "R5", "R10", "R2"};

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
   endtask

   task automatic wr_ctl(input logic [15:0] v);
      ctl_wdata = v;
      ctl_we    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ctl_we    = 1'b0;
   endtask

   task automatic wr_prd(input int v);
      prd_wdata = CNT_W'(v);
      prd_we    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      prd_we    = 1'b0;
   endtask

   // leaves the bench at the negedge right after the starting control write
   task automatic start(input logic [15:0] ctl, input int prd);
      do_reset();
      wr_ctl((ctl & 16'h3FFF) | 16'h0008);
      wr_prd(prd);
      wr_ctl(ctl | 16'h0008);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected finish");
         report();
         $finish;
      end
   end

   initial begin
      int zc;
      int pc;
      int bad;

      // R1 reset state
      do_reset();
      check("R1 cnt", int'(cnt), 0);
      check("R1 dir", int'(dir_down), 0);
      check("R1 strobes", int'({zero_stb, prd_stb}), 0);

      // table of mode / period vectors
      for (int i = 0; i < NV; i++) begin
         start(V_CTL[i], V_PRD[i]);
         step(V_N[i]);
         check({V_REQ[i], " cnt"}, int'(cnt), V_CNT[i]);
         check({V_REQ[i], " dir"}, int'(dir_down), V_DIR[i]);
      end

      // R11 strobes: up, period 3, 8 ticks -> 1,2,3,0,1,2,3,0
      start(16'hC000, 3);
      zc = 0; pc = 0; bad = 0;
      for (int i = 0; i < 8; i++) begin
         step(1);
         zc += int'(zero_stb);
         pc += int'(prd_stb);
         if (zero_stb && cnt != 0) bad++;
         if (prd_stb && cnt != 3) bad++;
      end
      check("R11 zero pulses", zc, 2);
      check("R11 period pulses", pc, 2);
      check("R11 pulse alignment", bad, 0);

      // R6 prescale 2^1 * 4 = 8
      start(16'hC000 | 16'h0400 | 16'h0100, 100);
      step(7);
      check("R6 div8 before", int'(cnt), 0);
      step(1);
      check("R6 div8 first", int'(cnt), 1);
      step(16);
      check("R6 div8 third", int'(cnt), 3);

      // R6 prescale 1 * 6 = 6
      start(16'hC000 | 16'h0180, 100);
      step(11);
      check("R6 div6 before", int'(cnt), 1);
      step(1);
      check("R6 div6 second", int'(cnt), 2);

      // R7 shadow load: old period 4 rules until zero, then 2
      do_reset();
      wr_ctl(16'h0008);
      wr_prd(4);
      wr_ctl(16'hC000);
      wr_prd(2);
      step(2);
      check("R7 shadow keeps old", int'(cnt), 3);
      step(4);
      check("R7 shadow new top", int'(cnt), 2);
      step(1);
      check("R7 shadow new wrap", int'(cnt), 0);

      // R7 immediate load: new period 2 at once
      do_reset();
      wr_ctl(16'h0008);
      wr_prd(4);
      wr_ctl(16'hC008);
      wr_prd(2);
      step(2);
      check("R7 immediate wrap", int'(cnt), 0);

      // R8 halt on next tick
      start(16'hC000, 10);
      step(3);
      check("R8 running", int'(cnt), 3);
      wr_ctl(16'h0008);
      zc = 0;
      for (int i = 0; i < 5; i++) begin
         step(1);
         zc += int'(zero_stb) + int'(prd_stb);
      end
      check("R8 held", int'(cnt), 4);
      check("R8 R11 no strobes halted", zc, 0);

      // R9 stop at end of cycle
      start(16'hC000, 5);
      step(2);
      wr_ctl(16'h4008);
      step(1);
      check("R9 still moving", int'(cnt), 4);
      zc = 0;
      for (int i = 0; i < 8; i++) begin
         step(1);
         zc += int'(zero_stb);
      end
      check("R9 held at zero", int'(cnt), 0);
      check("R9 one zero pulse", zc, 1);

      // R1 reset in mid-run
      start(16'hC002, 6);
      step(8);
      do_reset();
      check("R1 mid-run cnt", int'(cnt), 0);
      check("R1 mid-run dir", int'(dir_down), 0);

      done = 1'b1;
      report();
      $finish;
   end

endmodule